// File: doc/BRIEF.md
# Parallel-Word PWM Generator

This block produces a pulse-width modulated waveform as a stream of W-bit words, one per core clock, for an external serializer that shifts each word out bit by bit. Every bit of a word stands for one fine time step, so the waveform resolution is W times finer than the core clock period. With the default width of 10 and a 100 MHz core clock the fine step is 1 ns. A 5000-step period therefore gives a 200 kHz PWM rate without any fast logic. The same block also suits a 4-bit word that feeds four clock phases spaced 90 degrees apart.

The block tracks the fine-step position of bit 0 of the current word within the PWM period. For every bit it compares that bit's position against the duty value in parallel. A period boundary may fall in the middle of a word. The bits after the boundary then start counting again from position 0 of the next period. New period and duty settings are accepted only at a boundary, so a period is never built from a mix of old and new settings. The serializer path carries the raw word with no line encoding.

Top module: `pwmser_top`

## Requirements
- R1: `valid_o` is 0 while `rst_n` is low and is 1 on every cycle after reset release, one word per clock with no gaps.
- R2: While in reset `word_o` is all zeros. The reset settings are a period of W steps and a duty of 0, so the first word after release is all zeros. Inputs sampled on that first edge set the second period.
- R3: Bit 0 of `word_o` is the earliest fine step and bit W-1 the latest. Bit k is 1 exactly when its fine-step position within the period is less than the active duty.
- R4: The position of bit 0 advances by W every cycle. When a position reaches the active period it wraps to 0, and the remaining bits of that word count on from 0 of the next period.
- R5: `period_i` and `duty_i` are sampled only on the clock edge whose word contains the period boundary. The boundary may also fall exactly at the word's end. The bits after the boundary in that word already use the sampled values. On every other edge the inputs have no effect.
- R6: A duty of 0 gives all-zero words for the whole period.
- R7: A duty equal to or greater than the period gives all-one words for the whole period.
- R8: A period value below W is taken as W, so at most one boundary falls inside any word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | PW | Requested period length in fine steps |
| duty_i | input | PW | Requested high time in fine steps |
| word_o | output | W | Parallel word, bit 0 earliest in time |
| valid_o | output | 1 | Word strobe, high every cycle after reset |

## Verification
Every word appears on `word_o` one clock edge after the edge on which it was computed. Any input value that edge samples can already shape the bits after a boundary in that same word. The bench drives inputs on the falling edge and keeps a per-fine-step model of the period counter. At each falling edge it pushes the word the model expects for the coming rising edge. The monitor compares that word 2 ns after the rising edge, so each expected word meets exactly the edge that registers it. Reset values are checked while reset is still held.

// File: rtl/pwmser_pkg.sv
package pwmser_pkg;
    // Default word width: fine steps carried per core clock.
    parameter int unsigned PWMSER_W_DEF  = 10;
    // Default width of the period and duty values.
    parameter int unsigned PWMSER_PW_DEF = 16;
endpackage

// File: rtl/pwmser_slot_cmp.sv
// Decides one bit of the word: where its fine step falls and whether it is high.
module pwmser_slot_cmp #(
    parameter int unsigned PW = 16,
    parameter int unsigned K  = 0
) (
    input  logic [PW-1:0] base_pos,
    input  logic [PW-1:0] per_cur,
    input  logic [PW-1:0] duty_cur,
    input  logic [PW-1:0] duty_nxt,
    output logic          bit_o
);
    localparam logic [PW:0] OFS = (PW+1)'(K);

    logic [PW:0] pos_raw;
    logic [PW:0] pos_wrap;
    logic        past_end;

    always_comb begin
        pos_raw  = {1'b0, base_pos} + OFS;
        past_end = pos_raw >= {1'b0, per_cur};
        pos_wrap = pos_raw - {1'b0, per_cur};
        if (past_end) begin
            bit_o = pos_wrap[PW-1:0] < duty_nxt;
        end else begin
            bit_o = pos_raw[PW-1:0] < duty_cur;
        end
    end
endmodule

// File: rtl/pwmser_phase.sv
// Advances the bit-0 position by one word and detects a period boundary.
module pwmser_phase #(
    parameter int unsigned W  = 10,
    parameter int unsigned PW = 16
) (
    input  logic [PW-1:0] base_pos,
    input  logic [PW-1:0] per_cur,
    input  logic [PW-1:0] per_req,
    output logic [PW-1:0] base_nxt,
    output logic [PW-1:0] per_req_c,
    output logic          wrap
);
    localparam logic [PW:0]   STEP  = (PW+1)'(W);
    localparam logic [PW-1:0] MIN_P = PW'(W);

    logic [PW:0] end_pos;
    logic [PW:0] end_wrap;

    always_comb begin
        end_pos   = {1'b0, base_pos} + STEP;
        end_wrap  = end_pos - {1'b0, per_cur};
        wrap      = end_pos >= {1'b0, per_cur};
        base_nxt  = wrap ? end_wrap[PW-1:0] : end_pos[PW-1:0];
        per_req_c = (per_req < MIN_P) ? MIN_P : per_req;
    end
endmodule

// File: rtl/pwmser_top.sv
module pwmser_top
    import pwmser_pkg::*;
#(
    parameter int unsigned W  = PWMSER_W_DEF,
    parameter int unsigned PW = PWMSER_PW_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_i,
    input  logic [PW-1:0] duty_i,
    output logic [W-1:0]  word_o,
    output logic          valid_o
);
    localparam logic [PW-1:0] RST_PER = PW'(W);

    typedef struct packed {
        logic [PW-1:0] base;
        logic [PW-1:0] per;
        logic [PW-1:0] duty;
        logic [W-1:0]  word;
        logic          vld;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [PW-1:0] base_nxt;
    logic [PW-1:0] per_req_c;
    logic          wrap;
    logic [W-1:0]  word_nxt;

    pwmser_phase #(.W(W), .PW(PW)) u_phase (
        .base_pos (st_q.base),
        .per_cur  (st_q.per),
        .per_req  (period_i),
        .base_nxt (base_nxt),
        .per_req_c(per_req_c),
        .wrap     (wrap)
    );

    for (genvar k = 0; k < W; k++) begin : g_slot
        pwmser_slot_cmp #(.PW(PW), .K(k)) u_cmp (
            .base_pos(st_q.base),
            .per_cur (st_q.per),
            .duty_cur(st_q.duty),
            .duty_nxt(duty_i),
            .bit_o   (word_nxt[k])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.base = base_nxt;
        st_d.word = word_nxt;
        st_d.vld  = 1'b1;
        if (wrap) begin
            st_d.per  = per_req_c;
            st_d.duty = duty_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{base: '0, per: RST_PER, duty: '0, word: '0, vld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    logic [PW-1:0] base_q;
    logic [PW-1:0] per_q;
    logic [PW-1:0] duty_q;
    assign base_q  = st_q.base;
    assign per_q   = st_q.per;
    assign duty_q  = st_q.duty;
    assign word_o  = st_q.word;
    assign valid_o = st_q.vld;
endmodule

// File: rtl/pwmser_chk.sv
module pwmser_chk #(
    parameter int unsigned W  = 10,
    parameter int unsigned PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] period_i,
    input logic [PW-1:0] duty_i,
    input logic [W-1:0]  word_o,
    input logic          valid_o,
    input logic [PW-1:0] base_q,
    input logic [PW-1:0] per_q,
    input logic [PW-1:0] duty_q
);
    localparam logic [PW-1:0] MIN_P = PW'(W);
    localparam logic [PW:0]   STEP  = (PW+1)'(W);

    logic [PW-1:0] per_in_c;
    logic          mid_period;
    assign per_in_c   = (period_i < MIN_P) ? MIN_P : period_i;
    assign mid_period = ({1'b0, base_q} + STEP) < {1'b0, per_q};

    a_r1_valid_steady: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> valid_o);

    a_r6_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(duty_q) == '0 && $past(duty_i) == '0) |-> word_o == '0);

    a_r7_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(duty_q) >= $past(per_q) && $past(duty_i) >= $past(per_in_c))
        |-> word_o == '1);

    a_r5_hold_settings: assert property (@(posedge clk) disable iff (!rst_n)
        mid_period |=> ($stable(per_q) && $stable(duty_q)));

    a_r4_base_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        base_q < per_q);

    a_r8_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
        per_q >= MIN_P);
endmodule

bind pwmser_top pwmser_chk #(.W(W), .PW(PW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .period_i(period_i),
    .duty_i  (duty_i),
    .word_o  (word_o),
    .valid_o (valid_o),
    .base_q  (base_q),
    .per_q   (per_q),
    .duty_q  (duty_q)
);

// File: tb/tb_pwmser_top.sv
module tb_pwmser_top;
    localparam int W  = 10;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] period_i = '0;
    logic [PW-1:0] duty_i = '0;
    logic [W-1:0]  word_o;
    logic          valid_o;

    always #5 clk = ~clk;

    pwmser_top #(.W(W), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
        .word_o(word_o), .valid_o(valid_o)
    );

    typedef struct {
        logic [W-1:0] word;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // Fine-step model: position, active period and active duty.
    int m_pos  = 0;
    int m_per  = W;
    int m_duty = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Driver: present inputs for one word, then push the word the model predicts.
    task automatic drive_word(input int per, input int duty, input string tag);
        exp_t e;
        @(negedge clk);
        period_i = PW'(per);
        duty_i   = PW'(duty);
        e.tag = tag;
        for (int k = 0; k < W; k++) begin
            e.word[k] = (m_pos < m_duty);
            m_pos++;
            if (m_pos == m_per) begin
                m_pos  = 0;
                m_per  = (per < W) ? W : per;   // R8 floor
                m_duty = duty;
            end
        end
        exp_q.push_back(e);
    endtask

    task automatic drive_n(input int n, input int per, input int duty, input string tag);
        for (int i = 0; i < n; i++) drive_word(per, duty, tag);
    endtask

    // Monitor: compare 2 ns after every rising edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(word_o === e.word, e.tag, "word", int'(word_o), int'(e.word));
                check(valid_o === 1'b1, "R1", "valid", int'(valid_o), 1);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid_o === 1'b0, "R1", "valid in reset", int'(valid_o), 0);
        check(word_o === '0, "R2", "word in reset", int'(word_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: first word comes from reset settings; these inputs load period 25.
        period_i = PW'(25);
        duty_i   = PW'(7);
        exp_q.push_back('{word: '0, tag: "R2"});
        m_pos = 0; m_per = 25; m_duty = 7;
        // R3/R4: boundaries land mid-word
        drive_n(20, 25, 7, "R4");
        // R5: change requested mid-period, applied only at a boundary
        drive_n(2, 25, 7, "R3");
        drive_n(12, 25, 18, "R5");
        drive_n(12, 37, 3, "R5");
        // R6 zero duty
        drive_n(15, 40, 0, "R6");
        // R7 duty at and above period
        drive_n(12, 30, 30, "R7");
        drive_n(12, 30, 45, "R7");
        drive_n(6, 10, 9, "R3");
        // R8 short period
        drive_n(12, 3, 2, "R8");
        drive_n(8, 0, 1, "R8");
        // long period near the 5000-step target
        drive_n(1100, 5000, 2503, "R4");
        drive_n(4, 5000, 2503, "R4");
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule